// File: doc/BRIEF.md
# Interrupt and Abort Status Unit

This block gathers the event sources of a two-wire bus master into one status word and turns them into a single interrupt line. Ten of the sources are pulse events: a one-cycle pulse sets a sticky status bit that stays set until software clears it. Two sources, TX empty and RX full, are levels computed from FIFO fill levels against programmable thresholds. These two always follow the FIFO state and cannot be cleared.

A mask register selects which status bits reach the interrupt line. Software clears sticky bits by reading clear registers. Each clearable source has its own clear register, and one combined clear register clears every clearable bit at once.

When a transfer is aborted, the bit engine presents a reason vector together with an abort strobe. The reason bits are collected into a 16-bit abort-source register, and the TX abort status bit is raised in the same cycle. Read data is combinational and shows the state before the clock edge on which the read takes effect.

Top module: `irq_abort_status`

## Requirements
- R1: After synchronous reset, all sticky status bits, the mask register and the abort-source register are zero, and `irq` is low.
- R2: Each status bit has a fixed position: RX underflow 0, RX overflow 1, RX full 2, TX overflow 3, TX empty 4, read request 5, TX abort 6, RX done 7, activity 8, stop detected 9, start detected 10, general call 11. A pulse on `evt_pulse[i]` at a pulse position (0, 1, 3, 5, 7 to 11) sets bit i on the next edge. The bit then holds until it is cleared.
- R3: Bit 4 is 1 exactly while `tx_level <= tx_thresh`. Bit 2 is 1 exactly while `rx_level >= rx_thresh`. Pulses on `evt_pulse[2]`, `evt_pulse[4]` and `evt_pulse[6]` have no effect, and no clear read changes bits 2 or 4.
- R4: A read at 0x34 returns the 12 status bits. A read at 0x30 returns the mask, and a write at 0x30 loads the mask from `reg_wdata`. A read at 0x2c returns the status ANDed with the mask. Upper data bits read as 0.
- R5: `irq` is the OR of all masked status bits, so it is low whenever the mask is zero.
- R6: A read at one of these addresses clears one bit and returns that bit's prior value in bit 0: 0x44 bit 0, 0x48 bit 1, 0x4c bit 3, 0x50 bit 5, 0x54 bit 6, 0x58 bit 7, 0x5c bit 8, 0x60 bit 9, 0x64 bit 10, 0x68 bit 11. No other bit changes.
- R7: A read at 0x40 returns `irq` in bit 0. It clears every sticky bit and the abort-source register.
- R8: `abrt_valid` sets status bit 6 and ORs `abrt_reason` into the abort-source register, which is read at 0x80. The reason bits are: 7-bit address NACK 0, first 10-bit address byte NACK 1, second 10-bit address byte NACK 2, data NACK 3, general call NACK 4, general call read 5, master disabled 11, arbitration lost 12.
- R9: A read at 0x54 clears the abort-source register together with status bit 6.
- R10: When a setting event and a clear read of the same bit fall in the same cycle, the bit stays set. When an abort and an abort-clearing read coincide, the abort-source register holds exactly the new reason.
- R11: Reads at any other address, or cycles with `reg_rd` low, return 0 and clear nothing. Writes to any address other than 0x30 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_pulse | input | 12 | One-cycle event pulses, indexed by status bit |
| tx_level | input | LVL_W | TX FIFO fill level |
| tx_thresh | input | LVL_W | TX empty threshold |
| rx_level | input | LVL_W | RX FIFO fill level |
| rx_thresh | input | LVL_W | RX full threshold |
| abrt_valid | input | 1 | Transfer abort strobe |
| abrt_reason | input | 16 | Abort reason bits, valid with the strobe |
| reg_rd | input | 1 | Register read strobe (clear side effects apply) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 12 | Write data (mask) |
| reg_rdata | output | 16 | Combinational read data |
| irq | output | 1 | Interrupt line |

## Verification
The hardest case to reach from the ports is a new event that arrives in the same cycle as the read that would clear it, since random traffic seldom lines the two up. The bench therefore walks every clearable source through three steps: a cycle that sets the bit, a cycle that reads the bit's own clear register while pulsing the same source again, and a cycle that reads the raw status. It does the same for an abort that coincides with reads at 0x54 and 0x40, using a fresh reason vector. A behavioural model compares every read and the interrupt line on every cycle, during both this directed walk and the long random stretch that follows.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;

    localparam int EVT_N  = 12;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 8;

    typedef logic [EVT_N-1:0]  evt_vec_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    // status bit positions
    localparam int EV_RX_UNDER = 0;
    localparam int EV_RX_OVER  = 1;
    localparam int EV_RX_FULL  = 2;
    localparam int EV_TX_OVER  = 3;
    localparam int EV_TX_EMPTY = 4;
    localparam int EV_RD_REQ   = 5;
    localparam int EV_TX_ABORT = 6;
    localparam int EV_RX_DONE  = 7;
    localparam int EV_ACTIVITY = 8;
    localparam int EV_STOP     = 9;
    localparam int EV_START    = 10;
    localparam int EV_GEN_CALL = 11;

    localparam evt_vec_t LEVEL_BITS = (evt_vec_t'(1) << EV_RX_FULL) | (evt_vec_t'(1) << EV_TX_EMPTY);
    localparam evt_vec_t ABORT_BIT  = evt_vec_t'(1) << EV_TX_ABORT;
    localparam evt_vec_t PULSE_BITS = ~(LEVEL_BITS | ABORT_BIT);
    localparam evt_vec_t STICKY_BITS = ~LEVEL_BITS;

    // register offsets
    localparam addr_t A_MASKED   = 8'h2c;
    localparam addr_t A_MASK     = 8'h30;
    localparam addr_t A_RAW      = 8'h34;
    localparam addr_t A_CLR_ALL  = 8'h40;
    localparam addr_t A_ABRT_SRC = 8'h80;

    typedef struct packed {
        evt_vec_t src;   // sticky bits to drop
        logic     abrt;  // drop abort reasons
    } clr_cmd_t;

    // status bit selected by an individual clear register, zero if none
    function automatic evt_vec_t clr_target(addr_t a);
        evt_vec_t v;
        v = '0;
        case (a)
            8'h44: v[EV_RX_UNDER] = 1'b1;
            8'h48: v[EV_RX_OVER]  = 1'b1;
            8'h4c: v[EV_TX_OVER]  = 1'b1;
            8'h50: v[EV_RD_REQ]   = 1'b1;
            8'h54: v[EV_TX_ABORT] = 1'b1;
            8'h58: v[EV_RX_DONE]  = 1'b1;
            8'h5c: v[EV_ACTIVITY] = 1'b1;
            8'h60: v[EV_STOP]     = 1'b1;
            8'h64: v[EV_START]    = 1'b1;
            8'h68: v[EV_GEN_CALL] = 1'b1;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/irq_level_cmp.sv
module irq_level_cmp
    import irq_status_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] tx_thresh,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_thresh,
    output evt_vec_t         lvl_bits
);

    always_comb begin
        lvl_bits              = '0;
        lvl_bits[EV_TX_EMPTY] = (tx_level <= tx_thresh);
        lvl_bits[EV_RX_FULL]  = (rx_level >= rx_thresh);
    end

endmodule

// File: rtl/irq_event_bank.sv
module irq_event_bank
    import irq_status_pkg::*;
#(
    parameter int N = EVT_N
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    output logic [N-1:0] raw
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        logic bit_q;

        always_ff @(posedge clk) begin
            if (rst)
                bit_q <= 1'b0;
            else if (set[i])
                bit_q <= 1'b1;
            else if (clr[i])
                bit_q <= 1'b0;
        end

        assign raw[i] = bit_q;

        AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(set[i])) |-> raw[i]); // R10

        AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(clr[i]) && !$past(set[i])) |-> !raw[i]); // R6

        AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(set[i]) && !$past(clr[i])) |-> (raw[i] == $past(raw[i]))); // R2
    end

endmodule

// File: rtl/irq_abort_latch.sv
module irq_abort_latch
    import irq_status_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  cap,
    input  word_t reason,
    input  logic  clr,
    output word_t src
);

    word_t src_q;

    always_ff @(posedge clk) begin
        if (rst)
            src_q <= '0;
        else if (clr)
            src_q <= cap ? reason : '0;
        else if (cap)
            src_q <= src_q | reason;
    end

    assign src = src_q;

    AST_ABRT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cap)) |-> ((src & $past(reason)) == $past(reason))); // R8

    AST_ABRT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(clr) && !$past(cap)) |-> (src == '0)); // R9

endmodule

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
    import irq_status_pkg::*;
(
    input  logic     rd,
    input  addr_t    addr,
    input  evt_vec_t raw,
    input  evt_vec_t mask,
    input  logic     irq,
    input  word_t    abrt_src,
    output clr_cmd_t clr,
    output word_t    rdata
);

    evt_vec_t sel;

    assign sel = clr_target(addr);

    always_comb begin
        clr.src  = '0;
        clr.abrt = 1'b0;
        if (rd) begin
            if (addr == A_CLR_ALL) begin
                clr.src  = STICKY_BITS;
                clr.abrt = 1'b1;
            end else begin
                clr.src  = sel & STICKY_BITS;
                clr.abrt = sel[EV_TX_ABORT];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (rd) begin
            case (addr)
                A_MASKED:   rdata = word_t'(raw & mask);
                A_MASK:     rdata = word_t'(mask);
                A_RAW:      rdata = word_t'(raw);
                A_ABRT_SRC: rdata = abrt_src;
                A_CLR_ALL:  rdata = word_t'(irq);
                default:    rdata = word_t'(|(raw & sel));
            endcase
        end
    end

endmodule

// File: rtl/irq_abort_status.sv
module irq_abort_status
    import irq_status_pkg::*;
#(
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [11:0]      evt_pulse,
    input  logic [LVL_W-1:0] tx_level,
    input  logic [LVL_W-1:0] tx_thresh,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_thresh,
    input  logic             abrt_valid,
    input  logic [15:0]      abrt_reason,
    input  logic             reg_rd,
    input  logic             reg_wr,
    input  logic [7:0]       reg_addr,
    input  logic [11:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    output logic             irq
);

    evt_vec_t set_vec;
    evt_vec_t sticky_q;
    evt_vec_t lvl_bits;
    evt_vec_t raw_all;
    evt_vec_t mask_q;
    word_t    abrt_src;
    clr_cmd_t clr;

    assign set_vec = (evt_pulse & PULSE_BITS) | (abrt_valid ? ABORT_BIT : '0);

    irq_level_cmp #(.LVL_W(LVL_W)) u_lvl (
        .tx_level  (tx_level),
        .tx_thresh (tx_thresh),
        .rx_level  (rx_level),
        .rx_thresh (rx_thresh),
        .lvl_bits  (lvl_bits)
    );

    irq_event_bank #(.N(EVT_N)) u_bank (
        .clk (clk),
        .rst (rst),
        .set (set_vec),
        .clr (clr.src),
        .raw (sticky_q)
    );

    irq_abort_latch u_abrt (
        .clk    (clk),
        .rst    (rst),
        .cap    (abrt_valid),
        .reason (abrt_reason),
        .clr    (clr.abrt),
        .src    (abrt_src)
    );

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (reg_wr && reg_addr == A_MASK)
            mask_q <= reg_wdata;
    end

    assign raw_all = (sticky_q & STICKY_BITS) | lvl_bits;
    assign irq     = |(raw_all & mask_q);

    irq_reg_decode u_dec (
        .rd       (reg_rd),
        .addr     (reg_addr),
        .raw      (raw_all),
        .mask     (mask_q),
        .irq      (irq),
        .abrt_src (abrt_src),
        .clr      (clr),
        .rdata    (reg_rdata)
    );

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq); // R5

    AST_NO_SILENT_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(reg_rd)) |-> ((sticky_q & $past(sticky_q)) == $past(sticky_q))); // R11

endmodule

// File: tb/irq_abort_status_tb.sv
module irq_abort_status_tb;

    localparam int LVL_W = 5;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [11:0]      evt_pulse = '0;
    logic [LVL_W-1:0] tx_level = 5'd5, tx_thresh = 5'd0;
    logic [LVL_W-1:0] rx_level = 5'd0, rx_thresh = 5'd1;
    logic             abrt_valid = 1'b0;
    logic [15:0]      abrt_reason = '0;
    logic             reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0]       reg_addr = '0;
    logic [11:0]      reg_wdata = '0;
    logic [15:0]      reg_rdata;
    logic             irq;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    string phase = "";

    // model state
    bit [11:0] m_sticky;
    bit [11:0] m_mask;
    bit [15:0] m_abrt;

    irq_abort_status #(.LVL_W(LVL_W)) u_dut (
        .clk, .rst, .evt_pulse, .tx_level, .tx_thresh, .rx_level, .rx_thresh,
        .abrt_valid, .abrt_reason, .reg_rd, .reg_wr, .reg_addr, .reg_wdata,
        .reg_rdata, .irq
    );

    always #4 clk = ~clk;   // 125 MHz

    initial begin
        while (cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual cycles %0d expected < 150000", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // bit index cleared by an individual clear register, -1 if none (R6)
    function automatic int clr_idx(bit [7:0] a);
        case (a)
            8'h44: return 0;
            8'h48: return 1;
            8'h4c: return 3;
            8'h50: return 5;
            8'h54: return 6;
            8'h58: return 7;
            8'h5c: return 8;
            8'h60: return 9;
            8'h64: return 10;
            8'h68: return 11;
            default: return -1;
        endcase
    endfunction

    function automatic bit [11:0] m_raw();
        bit [11:0] r;
        r = m_sticky;
        r[4] = (tx_level <= tx_thresh);
        r[2] = (rx_level >= rx_thresh);
        return r;
    endfunction

    function automatic bit m_irq();
        return |(m_raw() & m_mask);
    endfunction

    function automatic bit [15:0] m_rdata();
        bit [11:0] r;
        int k;
        r = m_raw();
        if (!reg_rd) return 16'h0;
        if (reg_addr == 8'h2c) return {4'h0, r & m_mask};
        if (reg_addr == 8'h30) return {4'h0, m_mask};
        if (reg_addr == 8'h34) return {4'h0, r};
        if (reg_addr == 8'h80) return m_abrt;
        if (reg_addr == 8'h40) return {15'h0, m_irq()};
        k = clr_idx(reg_addr);
        if (k >= 0) return {15'h0, r[k]};
        return 16'h0;
    endfunction

    function automatic string addr_tag(bit [7:0] a);
        if (!reg_rd) return "R11";
        if (a == 8'h2c || a == 8'h30 || a == 8'h34) return "R4";
        if (a == 8'h40) return "R7";
        if (a == 8'h54) return "R9";
        if (a == 8'h80) return "R8";
        if (clr_idx(a) >= 0) return "R6";
        return "R11";
    endfunction

    task automatic compare();
        bit [15:0] er;
        bit ei;
        er = m_rdata();
        ei = m_irq();
        n_cmp++;
        if (reg_rdata !== er) begin
            n_bad++;
            $display("FAIL %s%s rdata @%h: actual %h expected %h", addr_tag(reg_addr), phase, reg_addr, reg_rdata, er);
        end
        n_cmp++;
        if (irq !== ei) begin
            n_bad++;
            $display("FAIL R5%s irq: actual %b expected %b", phase, irq, ei);
        end
    endtask

    task automatic model_edge();
        bit clr_abrt;
        int k;
        if (rst) begin
            m_sticky = '0; m_mask = '0; m_abrt = '0;
            return;
        end
        clr_abrt = 1'b0;
        if (reg_rd) begin
            if (reg_addr == 8'h40) begin
                m_sticky = '0;
                clr_abrt = 1'b1;
            end else begin
                k = clr_idx(reg_addr);
                if (k >= 0) m_sticky[k] = 1'b0;
                if (k == 6) clr_abrt = 1'b1;
            end
        end
        // R3: positions 2, 4, 6 of the pulse input are ignored
        for (int i = 0; i < 12; i++)
            if (evt_pulse[i] && i != 2 && i != 4 && i != 6) m_sticky[i] = 1'b1;
        if (clr_abrt) m_abrt = '0;
        if (abrt_valid) begin
            m_sticky[6] = 1'b1;
            m_abrt = m_abrt | abrt_reason;
        end
        if (reg_wr && reg_addr == 8'h30) m_mask = reg_wdata;
    endtask

    // one cycle: inputs already set after negedge; check then advance
    task automatic step();
        #1 compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        evt_pulse = '0; abrt_valid = 1'b0; reg_rd = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd(bit [7:0] a);
        reg_rd = 1'b1; reg_addr = a;
        step();
    endtask

    initial begin
        m_sticky = '0; m_mask = '0; m_abrt = '0;
        @(negedge clk);
        phase = " reset";
        // R1: state during and right after reset
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
        phase = " R1";
        rd(8'h34); rd(8'h30); rd(8'h80); rd(8'h2c);

        // R4/R5: mask everything, levels quiet
        reg_wr = 1'b1; reg_addr = 8'h30; reg_wdata = 12'hfff;
        step();

        // R2 / R10: every clearable source: set, collide with its clear, observe, clear
        for (int a = 8'h44; a <= 8'h68; a += 4) begin
            int k;
            k = clr_idx(8'(a));
            phase = " R2";
            evt_pulse[k] = 1'b1;
            if (k == 6) begin abrt_valid = 1'b1; abrt_reason = 16'h0009; end
            step();
            rd(8'h34);
            phase = " R10";
            reg_rd = 1'b1; reg_addr = 8'(a); evt_pulse[k] = 1'b1;
            if (k == 6) begin abrt_valid = 1'b1; abrt_reason = 16'h1800; end
            step();
            rd(8'h34); rd(8'h80);
            phase = " R6";
            rd(8'(a)); rd(8'h34); rd(8'h80);
        end

        // R10 with combined clear and an abort
        phase = " R10";
        abrt_valid = 1'b1; abrt_reason = 16'h0030; step();
        reg_rd = 1'b1; reg_addr = 8'h40; abrt_valid = 1'b1; abrt_reason = 16'h0004; step();
        rd(8'h80); rd(8'h34);
        phase = " R7";
        evt_pulse = 12'hfff; step();
        rd(8'h40); rd(8'h34); rd(8'h80);

        // R3: ignored pulse positions and level sources
        phase = " R3";
        evt_pulse = 12'h054; step();
        rd(8'h34);
        tx_level = 5'd3; tx_thresh = 5'd3; rx_level = 5'd7; rx_thresh = 5'd7; step();
        rd(8'h34); rd(8'h40); rd(8'h34); rd(8'h2c);
        tx_level = 5'd4; rx_level = 5'd6; rd(8'h34);

        // R5: zero mask silences irq while status is present
        phase = " R5";
        evt_pulse = 12'hfab; step();
        reg_wr = 1'b1; reg_addr = 8'h30; reg_wdata = 12'h000; step();
        rd(8'h2c); rd(8'h30);
        // R11: write to another address leaves mask alone
        phase = " R11";
        reg_wr = 1'b1; reg_addr = 8'h34; reg_wdata = 12'hfff; step();
        rd(8'h30); rd(8'h7c); rd(8'h34);

        // random traffic
        phase = "";
        for (int n = 0; n < 4000; n++) begin
            int sel;
            if ($urandom_range(0, 3) == 0) evt_pulse = 12'(1 << $urandom_range(0, 11));
            if ($urandom_range(0, 15) == 0) begin
                abrt_valid = 1'b1;
                abrt_reason = 16'(1 << $urandom_range(0, 15));
            end
            if ($urandom_range(0, 7) == 0) begin
                tx_level = 5'($urandom_range(0, 7)); tx_thresh = 5'($urandom_range(0, 7));
                rx_level = 5'($urandom_range(0, 7)); rx_thresh = 5'($urandom_range(0, 7));
            end
            sel = $urandom_range(0, 19);
            reg_rd = ($urandom_range(0, 2) != 0);
            if (sel < 10) reg_addr = 8'(8'h44 + 4 * sel);
            else if (sel == 10) reg_addr = 8'h40;
            else if (sel == 11) reg_addr = 8'h2c;
            else if (sel == 12) reg_addr = 8'h30;
            else if (sel == 13) reg_addr = 8'h80;
            else if (sel == 14) reg_addr = 8'($urandom_range(0, 255));
            else reg_addr = 8'h34;
            if ($urandom_range(0, 11) == 0) begin
                reg_wr = 1'b1;
                reg_wdata = 12'($urandom_range(0, 4095));
            end
            step();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule